// File: doc/BRIEF.md
# Chained Dual-Channel Timer Counter

Two counter channels share one prescaled timer clock and one register window. Each channel counts ticks from a chosen divider tap. In waveform mode it drives an output line that is set, cleared or toggled when the count reaches one of two compare registers. Channel 1 can take the rising edges of channel 0's output line as its clock. Channel 0 is set so that its line rises once per full wrap, and channel 1 then holds the upper word of a wide free-running count. Software builds a coherent wide value by reading the upper word, then the lower word, then the upper word again.

A block-level strobe restarts both channels and the prescaler on the same clock edge. A key-checked lock protects the configuration registers. While the lock is set, writes to the mode, compare and chaining-mux registers have no effect. The control, interrupt-mask and strobe registers stay writable at all times.

Top module: `dual_chain_timer`

## Requirements
- R1: After reset both counters, compare registers, mode fields, enables and interrupt masks read 0 and both output lines are low. The lock register at 0xE4 reads 1, meaning locked.
- R2: The control register (window offset 0x00) has two write bits. Bit 0 = 1 starts the channel and bit 1 = 1 stops it; when both are set, stop wins. A read returns the run state in bit 0. A stopped channel holds its count.
- R3: Mode bits 2:0 pick the tick source. Values 0, 1, 2 and 3 give the timer clock divided by 2, 8, 32 and 128, taken from a shared prescaler that restarts at 0. A running channel adds 1 per tick and wraps from all ones to 0.
- R4: Mode bit 15 enables waveform mode. Bits 17:16 give the action on compare A (offset 0x14) and bits 19:18 give the action on compare C (offset 0x1C): 0 none, 1 set, 2 clear, 3 toggle. The action applies on a tick where the count equals the compare value. When A and C both match, C wins. With bit 15 clear the line holds its value.
- R5: Block-mode bits 3:2 (0xC4) set to 2 route channel 0's output line to channel 1's external clock. Channel 1 with mode bits 2:0 set to 6 then adds 1 on the edge after each rising edge of that line. Any other mux value gives channel 1 no ticks.
- R6: Writing 1 to bit 0 at 0xC0 zeroes both counters, both output lines and the prescaler on one edge. Run states are unchanged.
- R7: The lock register at 0xE4 accepts a write only when bits 31:8 hold 0x54494D; bit 0 of that write becomes the new lock state. Writes with any other key change nothing. While locked, writes to mode, compare A, compare C and block mode are ignored.
- R8: Each channel has an 8-bit interrupt mask. Writing to 0x24 sets the mask bits that are 1, writing to 0x28 clears the mask bits that are 1, and 0x2C reads the mask back. The lock does not affect these registers.
- R9: Channel n occupies a 0x40-byte window at n*0x40: control 0x00, mode 0x04, count 0x10 (read-only), compare A 0x14, compare C 0x1C. The mode register reads back only bits 2:0, 15 and 19:16. Unmapped addresses read 0.
- R10: Reading the count register has no side effect on counting or on the output lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| wave_o | output | 2 | Output line of each channel |

## Verification
The counting path is tried with each divider tap, with a free chained run lasting several wraps of channel 0, and with compare values placed so that A and C match on the same count. The last case separates C-over-A priority from the reverse. Lock tests write with the wrong key, then the right key, then lock again, to separate key checking from write gating. Stop/start patterns that set both control bits show which of the two wins. A strobe issued mid-run confirms that the prescaler phase restarts along with the counters.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
   localparam int ADDR_W = 8;
   localparam int OFF_W  = 6;

   localparam logic [OFF_W-1:0] OFF_CTRL = 6'h00;
   localparam logic [OFF_W-1:0] OFF_MODE = 6'h04;
   localparam logic [OFF_W-1:0] OFF_CV   = 6'h10;
   localparam logic [OFF_W-1:0] OFF_CMPA = 6'h14;
   localparam logic [OFF_W-1:0] OFF_CMPC = 6'h1C;
   localparam logic [OFF_W-1:0] OFF_IEN  = 6'h24;
   localparam logic [OFF_W-1:0] OFF_IDIS = 6'h28;
   localparam logic [OFF_W-1:0] OFF_IMSK = 6'h2C;

   localparam logic [OFF_W-1:0] OFF_SYNC = 6'h00;
   localparam logic [OFF_W-1:0] OFF_BMUX = 6'h04;
   localparam logic [OFF_W-1:0] OFF_LOCK = 6'h24;

   localparam logic [1:0]  WIN_BLOCK   = 2'd3;
   localparam logic [23:0] LOCK_KEY    = 24'h54494D;
   localparam logic [1:0]  BMUX_CHAIN  = 2'd2;
   localparam logic [2:0]  SEL_XCHAIN  = 3'd6;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_SET    = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_TOGGLE = 2'd3
   } wave_act_e;
endpackage

// File: rtl/dct_prescaler.sv
`timescale 1ns/1ps
module dct_prescaler #(
   parameter int NUM_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_i,
   output logic [NUM_DIV-1:0] div_tick_o
);
   localparam int PRE_W = 2 * NUM_DIV - 1;

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (sync_i)  pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end

   for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
      assign div_tick_o[k] = &pre_q[2*k:0];
   end

   AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (pre_q == '0)); // R6
   AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> (pre_q == $past(pre_q) + 1'b1)); // R3
endmodule

// File: rtl/dct_wprot.sv
`timescale 1ns/1ps
module dct_wprot import dct_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [31:0] wdata_i,
   output logic        locked_o
);
   logic locked_q;
   logic key_ok;

   assign key_ok = (wdata_i[31:8] == LOCK_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 locked_q <= 1'b1;
      else if (wr_i && key_ok)    locked_q <= wdata_i[0];
   end

   assign locked_o = locked_q;

   AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && (wdata_i[31:8] != LOCK_KEY)) |=> $stable(locked_q)); // R7
endmodule

// File: rtl/dct_channel.sv
`timescale 1ns/1ps
module dct_channel import dct_pkg::*; #(
   parameter int CNT_W   = 32,
   parameter int CH_IDX  = 0,
   parameter int NUM_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sync_i,
   input  logic [NUM_DIV-1:0] div_tick_i,
   input  logic               xc_edge_i,
   input  logic               wr_i,
   input  logic [OFF_W-1:0]   off_i,
   input  logic [31:0]        wdata_i,
   input  logic               cfg_ok_i,
   output logic               wave_o,
   output logic [31:0]        rdata_o
);
   localparam int IMR_W = 8;

   logic             en_q;
   logic [2:0]       sel_q;
   logic             wmode_q;
   wave_act_e        acta_q, actc_q;
   logic [CNT_W-1:0] cv_q, cmpa_q, cmpc_q;
   logic [IMR_W-1:0] imr_q;
   logic             wave_q;

   logic      int_tick, ext_tick, tick;
   wave_act_e act;
   logic      wave_nxt;

   always_comb begin
      int_tick = 1'b0;
      for (int k = 0; k < NUM_DIV; k++)
         if (sel_q == 3'(k)) int_tick = div_tick_i[k];
   end

   if (CH_IDX == 1) begin : g_chain_in
      assign ext_tick = (sel_q == SEL_XCHAIN) && xc_edge_i;
   end else begin : g_no_chain_in
      assign ext_tick = 1'b0;
   end

   assign tick = en_q && (int_tick || ext_tick);

   always_comb begin
      act = ACT_NONE;
      if (cv_q == cmpa_q) act = acta_q;
      if (cv_q == cmpc_q) act = actc_q;
      unique case (act)
         ACT_SET:    wave_nxt = 1'b1;
         ACT_CLEAR:  wave_nxt = 1'b0;
         ACT_TOGGLE: wave_nxt = ~wave_q;
         default:    wave_nxt = wave_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cv_q   <= '0;
         wave_q <= 1'b0;
      end else if (sync_i) begin
         cv_q   <= '0;
         wave_q <= 1'b0;
      end else if (tick) begin
         cv_q <= cv_q + 1'b1;
         if (wmode_q) wave_q <= wave_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         sel_q   <= '0;
         wmode_q <= 1'b0;
         acta_q  <= ACT_NONE;
         actc_q  <= ACT_NONE;
         cmpa_q  <= '0;
         cmpc_q  <= '0;
         imr_q   <= '0;
      end else if (wr_i) begin
         unique case (off_i)
            OFF_CTRL: begin
               if (wdata_i[1])      en_q <= 1'b0;
               else if (wdata_i[0]) en_q <= 1'b1;
            end
            OFF_MODE: if (cfg_ok_i) begin
               sel_q   <= wdata_i[2:0];
               wmode_q <= wdata_i[15];
               acta_q  <= wave_act_e'(wdata_i[17:16]);
               actc_q  <= wave_act_e'(wdata_i[19:18]);
            end
            OFF_CMPA: if (cfg_ok_i) cmpa_q <= wdata_i[CNT_W-1:0];
            OFF_CMPC: if (cfg_ok_i) cmpc_q <= wdata_i[CNT_W-1:0];
            OFF_IEN:  imr_q <= imr_q | wdata_i[IMR_W-1:0];
            OFF_IDIS: imr_q <= imr_q & ~wdata_i[IMR_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (off_i)
         OFF_CTRL: rdata_o = {31'b0, en_q};
         OFF_MODE: rdata_o = {12'b0, 2'(actc_q), 2'(acta_q), wmode_q, 12'b0, sel_q};
         OFF_CV:   rdata_o = 32'(cv_q);
         OFF_CMPA: rdata_o = 32'(cmpa_q);
         OFF_CMPC: rdata_o = 32'(cmpc_q);
         OFF_IMSK: rdata_o = {24'b0, imr_q};
         default:  rdata_o = '0;
      endcase
   end

   assign wave_o = wave_q;

   AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (cv_q == '0 && !wave_q)); // R6
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && tick) |=> (cv_q == $past(cv_q) + 1'b1)); // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && !tick) |=> $stable(cv_q)); // R2
   AST_WAVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && !wmode_q) |=> $stable(wave_q)); // R4
endmodule

// File: rtl/dual_chain_timer.sv
`timescale 1ns/1ps
module dual_chain_timer import dct_pkg::*; #(
   parameter int CNT_W   = 32,
   parameter int NUM_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [1:0]        wave_o
);
   localparam int NUM_CH = 2;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("dual_chain_timer: CNT_W must lie in 2..32");
   end
   if (NUM_DIV < 1 || NUM_DIV > 4) begin : g_bad_num_div
      $error("dual_chain_timer: NUM_DIV must lie in 1..4");
   end

   logic [1:0]         win;
   logic [OFF_W-1:0]   off;
   logic               blk_wr, sync, locked, lock_wr;
   logic [NUM_DIV-1:0] div_tick;
   logic [1:0]         bmux_q;
   logic               w0_d_q, xc_edge;
   logic [31:0]        ch_rdata [NUM_CH];

   assign win     = bus_addr[7:6];
   assign off     = bus_addr[OFF_W-1:0];
   assign blk_wr  = bus_wr && (win == WIN_BLOCK);
   assign sync    = blk_wr && (off == OFF_SYNC) && bus_wdata[0];
   assign lock_wr = blk_wr && (off == OFF_LOCK);

   dct_prescaler #(.NUM_DIV(NUM_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .sync_i(sync), .div_tick_o(div_tick));

   dct_wprot u_wprot (
      .clk(clk), .rst_n(rst_n), .wr_i(lock_wr), .wdata_i(bus_wdata),
      .locked_o(locked));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bmux_q <= '0;
         w0_d_q <= 1'b0;
      end else begin
         w0_d_q <= wave_o[0];
         if (blk_wr && off == OFF_BMUX && !locked) bmux_q <= bus_wdata[3:2];
      end
   end

   assign xc_edge = (bmux_q == BMUX_CHAIN) && wave_o[0] && !w0_d_q;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dct_channel #(.CNT_W(CNT_W), .CH_IDX(i), .NUM_DIV(NUM_DIV)) u_ch (
         .clk(clk), .rst_n(rst_n), .sync_i(sync), .div_tick_i(div_tick),
         .xc_edge_i(xc_edge), .wr_i(bus_wr && win == 2'(i)), .off_i(off),
         .wdata_i(bus_wdata), .cfg_ok_i(!locked), .wave_o(wave_o[i]),
         .rdata_o(ch_rdata[i]));
   end

   always_comb begin
      bus_rdata = '0;
      if (win == 2'd0)      bus_rdata = ch_rdata[0];
      else if (win == 2'd1) bus_rdata = ch_rdata[1];
      else if (win == WIN_BLOCK) begin
         if (off == OFF_BMUX)      bus_rdata = {28'b0, bmux_q, 2'b0};
         else if (off == OFF_LOCK) bus_rdata = {31'b0, locked};
      end
   end

   AST_LOCK_BMUX: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && blk_wr && off == OFF_BMUX) |=> $stable(bmux_q)); // R7
   AST_NO_CHAIN_WITHOUT_MUX: assert property (@(posedge clk) disable iff (!rst_n)
      (bmux_q != BMUX_CHAIN) |-> !xc_edge); // R5
endmodule

// File: tb/dual_chain_timer_tb.sv
`timescale 1ns/1ps
module dual_chain_timer_tb;
   localparam int W    = 8;
   localparam int CMOD = 1 << W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h10;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  wave_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   dual_chain_timer #(.CNT_W(W), .NUM_DIV(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wave_o(wave_o));

   // behavioural reference state
   int m_cv[2], m_ra[2], m_rc[2], m_sel[2], m_wm[2], m_aa[2], m_ac[2];
   int m_en[2], m_imr[2], m_w[2];
   int m_w0p, m_pre, m_bmux, m_lock;

   function automatic int apply_act(input int a, input int w);
      case (a)
         1: return 1;
         2: return 0;
         3: return 1 - w;
         default: return w;
      endcase
   endfunction

   function automatic logic [31:0] m_read(input logic [7:0] a);
      int c;
      int o;
      c = int'(a[7:6]);
      o = int'(a[5:0]);
      if (c < 2) begin
         case (o)
            'h00: return 32'(m_en[c]);
            'h04: return 32'(m_sel[c] + (m_wm[c] << 15) + (m_aa[c] << 16) + (m_ac[c] << 18));
            'h10: return 32'(m_cv[c]);
            'h14: return 32'(m_ra[c]);
            'h1C: return 32'(m_rc[c]);
            'h2C: return 32'(m_imr[c]);
            default: return 0;
         endcase
      end
      if (c == 3 && o == 'h04) return 32'(m_bmux << 2);
      if (c == 3 && o == 'h24) return 32'(m_lock);
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_cv[c] = 0; m_ra[c] = 0; m_rc[c] = 0; m_sel[c] = 0; m_wm[c] = 0;
            m_aa[c] = 0; m_ac[c] = 0; m_en[c] = 0; m_imr[c] = 0; m_w[c] = 0;
         end
         m_w0p = 0; m_pre = 0; m_bmux = 0; m_lock = 1;
      end else begin
         int t[2];
         int divs[4];
         int oldw0;
         int c, o;
         divs = '{2, 8, 32, 128};
         for (int ch = 0; ch < 2; ch++) begin
            t[ch] = 0;
            if (m_sel[ch] < 4) t[ch] = ((m_pre % divs[m_sel[ch]]) == divs[m_sel[ch]] - 1);
            if (ch == 1 && m_sel[ch] == 6 && m_bmux == 2 && m_w[0] == 1 && m_w0p == 0) t[ch] = 1;
            if (m_en[ch] == 0) t[ch] = 0;
         end
         oldw0 = m_w[0];
         if (bus_wr && bus_addr == 8'hC0 && bus_wdata[0]) begin
            m_cv = '{0, 0}; m_w = '{0, 0}; m_pre = 0;
         end else begin
            for (int ch = 0; ch < 2; ch++) if (t[ch]) begin
               int a;
               a = 0;
               if (m_cv[ch] == m_ra[ch]) a = m_aa[ch];
               if (m_cv[ch] == m_rc[ch]) a = m_ac[ch];
               if (m_wm[ch]) m_w[ch] = apply_act(a, m_w[ch]);
               m_cv[ch] = (m_cv[ch] + 1) % CMOD;
            end
            m_pre = (m_pre + 1) % 128;
         end
         m_w0p = oldw0;
         if (bus_wr) begin
            c = int'(bus_addr[7:6]);
            o = int'(bus_addr[5:0]);
            if (c < 2) begin
               case (o)
                  'h00: if (bus_wdata[1]) m_en[c] = 0; else if (bus_wdata[0]) m_en[c] = 1;
                  'h04: if (!m_lock) begin
                     m_sel[c] = int'(bus_wdata[2:0]); m_wm[c] = int'(bus_wdata[15]);
                     m_aa[c] = int'(bus_wdata[17:16]); m_ac[c] = int'(bus_wdata[19:18]);
                  end
                  'h14: if (!m_lock) m_ra[c] = int'(bus_wdata[W-1:0]);
                  'h1C: if (!m_lock) m_rc[c] = int'(bus_wdata[W-1:0]);
                  'h24: m_imr[c] = m_imr[c] | int'(bus_wdata[7:0]);
                  'h28: m_imr[c] = m_imr[c] & ~int'(bus_wdata[7:0]);
                  default: ;
               endcase
            end else if (c == 3) begin
               if (o == 'h04 && !m_lock) m_bmux = int'(bus_wdata[3:2]);
               if (o == 'h24 && bus_wdata[31:8] == 24'h54494D) m_lock = int'(bus_wdata[0]);
            end
         end
      end
   end

   // per-cycle comparison against the reference, mid-cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (wave_o !== {1'(m_w[1]), 1'(m_w[0])}) begin
            n_fail++;
            $display("FAIL R4 wave_o actual=%b expected=%0d%0d", wave_o, m_w[1], m_w[0]);
         end
         n_chk++;
         if (bus_rdata !== m_read(bus_addr)) begin
            n_fail++;
            $display("FAIL R9 read @%h actual=%h expected=%h", bus_addr, bus_rdata, m_read(bus_addr));
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #2;
      bus_wr = 1'b0; bus_addr = 8'h10;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
         bus_addr = i[0] ? 8'h50 : 8'h10;
      end
   endtask

   task automatic chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      @(negedge clk); #1;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s read @%h actual=%h expected=%h", tag, a, bus_rdata, exp);
      end
   endtask

   localparam logic [31:0] UNLOCK = {24'h54494D, 8'h00};
   localparam logic [31:0] RELOCK = {24'h54494D, 8'h01};

   initial begin
      #1000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      chk(8'h04, 32'h0, "R1"); chk(8'h10, 32'h0, "R1");
      chk(8'hE4, 32'h1, "R1"); chk(8'h6C, 32'h0, "R1");
      // R7 locked writes ignored, wrong key ignored
      wr(8'h14, 32'h5);  chk(8'h14, 32'h0, "R7");
      wr(8'hE4, {24'h123456, 8'h00}); chk(8'hE4, 32'h1, "R7");
      wr(8'hE4, UNLOCK); chk(8'hE4, 32'h0, "R7");
      // R8 mask set/clear, independent of lock
      wr(8'h24, 32'hFF); wr(8'h28, 32'h0F); chk(8'h2C, 32'hF0, "R8");
      wr(8'h68, 32'hFF); chk(8'h6C, 32'h0, "R8");
      // R9 mode read-back masking
      wr(8'h04, 32'hFFFF_FFFF); chk(8'h04, 32'h000F_8007, "R9");
      // configure chain: ch0 /2, set on A=1, clear on C=0x80; ch1 on chained clock
      wr(8'h04, 32'h0000_0000 | (1 << 15) | (1 << 16) | (2 << 18));
      wr(8'h14, 32'h1); wr(8'h1C, 32'h80);
      wr(8'h44, 32'h6 | (1 << 15));
      wr(8'hC4, 32'h2 << 2); chk(8'hC4, 32'h8, "R5");
      wr(8'h00, 32'h1); wr(8'h40, 32'h1);
      chk(8'h00, 32'h1, "R2");
      // R6/R3 sync then 20 edges at /2
      wr(8'hC0, 32'h1);
      bus_addr = 8'h10;
      repeat (20) @(posedge clk);
      chk(8'h10, 32'd10, "R3");
      // R10 repeated reads of the count leave it unchanged while stopped
      wr(8'h00, 32'h3);
      chk(8'h10, 32'd11, "R2"); chk(8'h10, 32'd11, "R10");
      wr(8'h00, 32'h1);
      // R5 chained run: 2000 edges after sync -> four rising edges of ch0
      wr(8'hC0, 32'h1);
      bus_addr = 8'h50;
      repeat (2000) @(posedge clk);
      chk(8'h50, 32'd4, "R5");
      // R3 divide by 8: 40 edges after sync -> 5 ticks
      wr(8'h04, 32'h1 | (1 << 15) | (1 << 16) | (2 << 18));
      wr(8'hC0, 32'h1);
      bus_addr = 8'h10;
      repeat (40) @(posedge clk);
      chk(8'h10, 32'd5, "R3");
      run(600);
      // R4 C over A priority with toggle on C
      wr(8'h04, 32'h0 | (1 << 15) | (1 << 16) | (3 << 18));
      wr(8'h14, 32'h5); wr(8'h1C, 32'h5);
      run(1200);
      // R4 /32 and /128 taps, non-waveform hold
      wr(8'h04, 32'h2 | (1 << 15) | (3 << 16));
      run(3000);
      wr(8'h04, 32'h3 | (3 << 16));
      run(3000);
      // R5 other mux value stops chained ticks
      wr(8'h04, 32'h0 | (1 << 15) | (1 << 16) | (2 << 18));
      wr(8'h1C, 32'h80); wr(8'h14, 32'h1);
      wr(8'hC4, 32'h1 << 2);
      wr(8'hC0, 32'h1);
      bus_addr = 8'h50;
      repeat (1100) @(posedge clk);
      chk(8'h50, 32'd0, "R5");
      // R7 relock and confirm config frozen
      wr(8'hE4, RELOCK);
      wr(8'h14, 32'h33); chk(8'h14, 32'h1, "R7");
      wr(8'hC4, 32'h2 << 2); chk(8'hC4, 32'h4, "R7");
      run(200);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule